// File: doc/BRIEF.md
# Device Idle Watchdog with SMI Request

This block watches one class of device activity, here video accesses, and raises a system-management interrupt request once that device has been idle for a programmed time. A down-counter is loaded with a programmable count. Each timebase tick decrements it. Each access that hits the watched address range reloads it. When the counter reaches zero, a sticky status bit is set, and an SMI request is driven for as long as that bit stays set. Firmware clears the bit by writing a one to it.

Counting is gated at several levels: a per-timer enable, a global timers enable, the global power-management enable, and the operating mode. The block counts only in the legacy APM mode, never in ACPI mode. Clearing the global timers enable freezes the counter at its current value. Setting it again resumes from that value without a reload. After an expiry the counter rests at zero until the next access, so each idle period raises exactly one SMI.

Top module: `idle_sentinel`

## Requirements
- R1: After a synchronous reset, `sts_o` and `smi_req_o` are 0.
- R2: With all gates open, `unit_en_i`=1 and `acpi_mode_i`=0, the counter decrements once per cycle in which `tick_i`=1. The tick that takes it from 1 to 0 sets `sts_o` at the next clock edge. `smi_req_o` is 1 exactly when `sts_o` is 1, the previous cycle had `acpi_mode_i`=0 and `pm_global_en_i`=1, and `sts_o` has been set for at least one edge. A cycle without a tick leaves the count unchanged.
- R3: `sts_o` is sticky. It returns to 0 only at the edge after a cycle with `sts_clr_i`=1 and no expiry.
- R4: A cycle with `hit_i`=1 while `unit_en_i`=1 reloads the counter with `reload_i`, which postpones expiry by a full period.
- R5: While `timers_en_i`=0 the counter holds its value. When it returns to 1, counting resumes from the held value without a reload.
- R6: While `acpi_mode_i`=1 the counter does not count, so no expiry is raised, and `smi_req_o` is 0 from the next edge.
- R7: While `pm_global_en_i`=0 the counter does not count, and `smi_req_o` is 0 from the next edge. `sts_o` keeps its value.
- R8: If an access hit and the final tick fall in the same cycle, the reload wins and `sts_o` is not set.
- R9: After an expiry the counter stays at zero. Further ticks raise no new status until an access reload.
- R10: A 0-to-1 change of `unit_en_i` loads the counter with `reload_i`.
- R11: If an expiry and `sts_clr_i` fall in the same cycle, `sts_o` is 1 after that edge.
- R12: A reload value of 0 leaves the counter at zero and raises no expiry, because an expiry needs a step from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase tick, one decrement per cycle high |
| hit_i | input | 1 | Access hit in the watched address range |
| reload_i | input | CNT_W | Programmed idle count |
| pm_global_en_i | input | 1 | Global power-management enable |
| timers_en_i | input | 1 | Global timers enable (freezes when 0) |
| unit_en_i | input | 1 | Per-timer enable |
| acpi_mode_i | input | 1 | 1 = ACPI mode (no counting), 0 = APM mode |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| sts_o | output | 1 | Sticky expiry status |
| smi_req_o | output | 1 | SMI request |

## Verification
The hardest situations to reach are the collisions in a single cycle: an access hit on the exact tick that would expire the counter, and a status clear on the exact tick of an expiry. The bench reaches both by loading a small count through a rising per-timer enable, then stepping ticks one at a time until the count is one. It then places the hit or the clear in the same cycle as the final tick. The freeze case is driven the same way, with the global timers enable dropped partway through a count, so that a model tracking the count on every clock shows whether the counter resumed or reloaded.

// File: rtl/idle_sentinel_pkg.sv
package idle_sentinel_pkg;

  // Operation applied to the idle counter in a given cycle.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/idle_gate.sv
module idle_gate
  import idle_sentinel_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tick_i,
  input  logic    hit_i,
  input  logic    pm_global_en_i,
  input  logic    timers_en_i,
  input  logic    unit_en_i,
  input  logic    acpi_mode_i,
  input  logic    cnt_zero_i,
  output cnt_op_e op_o,
  output logic    load_o
);

  logic uen_q;
  logic uen_rise;
  logic run_ok;

  always_ff @(posedge clk) begin
    if (rst) uen_q <= 1'b0;
    else     uen_q <= unit_en_i;
  end

  assign uen_rise = unit_en_i & ~uen_q;
  // Counting needs every gate open and the APM mode selected.
  assign run_ok   = pm_global_en_i & timers_en_i & unit_en_i & ~acpi_mode_i;
  assign load_o   = uen_rise | (hit_i & unit_en_i);

  always_comb begin
    if (load_o)                              op_o = CNT_LOAD;
    else if (run_ok && tick_i && !cnt_zero_i) op_o = CNT_DEC;
    else                                     op_o = CNT_HOLD;
  end

endmodule

// File: rtl/idle_counter.sv
module idle_counter
  import idle_sentinel_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CNT_LOAD: cnt_q <= reload_i;
        CNT_DEC:  cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign zero_o   = (cnt_q == '0);
  // Expiry is only the step from one to zero, so a zero load never fires.
  assign expire_o = (op_i == CNT_DEC) && (cnt_q == ONE);

endmodule

// File: rtl/idle_status.sv
module idle_status (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic clr_i,
  input  logic acpi_mode_i,
  input  logic pm_global_en_i,
  output logic sts_o,
  output logic smi_o
);

  logic sts_q;
  logic smi_q;
  logic sts_d;

  // A set on expiry beats a clear in the same cycle.
  assign sts_d = expire_i | (sts_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      smi_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      smi_q <= sts_d & ~acpi_mode_i & pm_global_en_i;
    end
  end

  assign sts_o = sts_q;
  assign smi_o = smi_q;

endmodule

// File: rtl/idle_sentinel.sv
module idle_sentinel
  import idle_sentinel_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             pm_global_en_i,
  input  logic             timers_en_i,
  input  logic             unit_en_i,
  input  logic             acpi_mode_i,
  input  logic             sts_clr_i,
  output logic             sts_o,
  output logic             smi_req_o
);

  cnt_op_e          op_w;
  logic             ld_w;
  logic             zero_w;
  logic             exp_w;
  logic [CNT_W-1:0] cnt_w;

  idle_gate gate_i (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick_i),
    .hit_i          (hit_i),
    .pm_global_en_i (pm_global_en_i),
    .timers_en_i    (timers_en_i),
    .unit_en_i      (unit_en_i),
    .acpi_mode_i    (acpi_mode_i),
    .cnt_zero_i     (zero_w),
    .op_o           (op_w),
    .load_o         (ld_w)
  );

  idle_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_w),
    .reload_i (reload_i),
    .cnt_o    (cnt_w),
    .zero_o   (zero_w),
    .expire_o (exp_w)
  );

  idle_status sts_i (
    .clk            (clk),
    .rst            (rst),
    .expire_i       (exp_w),
    .clr_i          (sts_clr_i),
    .acpi_mode_i    (acpi_mode_i),
    .pm_global_en_i (pm_global_en_i),
    .sts_o          (sts_o),
    .smi_o          (smi_req_o)
  );

endmodule

// File: rtl/idle_sentinel_chk.sv
module idle_sentinel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             hit_i,
  input logic             timers_en_i,
  input logic             unit_en_i,
  input logic             acpi_mode_i,
  input logic             pm_global_en_i,
  input logic             sts_clr_i,
  input logic             sts_o,
  input logic             smi_req_o,
  input logic             ld_w,
  input logic [CNT_W-1:0] cnt_w
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sts_o && !smi_req_o));

  a_r2_smi_needs_sts: assert property (@(posedge clk) disable iff (rst)
    smi_req_o |-> sts_o);

  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (sts_o && !sts_clr_i) |=> sts_o);

  a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
    (!timers_en_i && !ld_w) |=> $stable(cnt_w));

  a_r6_acpi_no_set: assert property (@(posedge clk) disable iff (rst)
    (acpi_mode_i && !sts_o) |=> !sts_o);

  a_r6_acpi_no_smi: assert property (@(posedge clk) disable iff (rst)
    acpi_mode_i |=> !smi_req_o);

  a_r7_pm_off_no_smi: assert property (@(posedge clk) disable iff (rst)
    !pm_global_en_i |=> !smi_req_o);

  a_r8_hit_wins: assert property (@(posedge clk) disable iff (rst)
    (hit_i && unit_en_i && !sts_o) |=> !sts_o);

  a_r9_rest_at_zero: assert property (@(posedge clk) disable iff (rst)
    ((cnt_w == '0) && !ld_w) |=> (cnt_w == '0));

endmodule

bind idle_sentinel idle_sentinel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .hit_i          (hit_i),
  .timers_en_i    (timers_en_i),
  .unit_en_i      (unit_en_i),
  .acpi_mode_i    (acpi_mode_i),
  .pm_global_en_i (pm_global_en_i),
  .sts_clr_i      (sts_clr_i),
  .sts_o          (sts_o),
  .smi_req_o      (smi_req_o),
  .ld_w           (ld_w),
  .cnt_w          (cnt_w)
);

// File: tb/idle_sentinel_tb_top.sv
`timescale 1ns/1ps
module idle_sentinel_tb_top;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 0, hit_i = 0, pm_global_en_i = 0, timers_en_i = 0;
  logic unit_en_i = 0, acpi_mode_i = 0, sts_clr_i = 0;
  logic [CNT_W-1:0] reload_i = '0;
  logic sts_o, smi_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  // Behavioural reference state.
  int m_cnt = 0;
  bit m_sts = 0, m_smi = 0, m_uen_prev = 0;

  always #5 clk = ~clk;

  idle_sentinel #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .hit_i(hit_i), .reload_i(reload_i),
    .pm_global_en_i(pm_global_en_i), .timers_en_i(timers_en_i),
    .unit_en_i(unit_en_i), .acpi_mode_i(acpi_mode_i), .sts_clr_i(sts_clr_i),
    .sts_o(sts_o), .smi_req_o(smi_req_o)
  );

  always @(posedge clk) begin
    bit exp_now;
    exp_now = 0;
    if (rst) begin
      m_cnt = 0; m_sts = 0; m_smi = 0; m_uen_prev = 0;
    end else begin
      if ((unit_en_i && !m_uen_prev) || (hit_i && unit_en_i)) begin
        m_cnt = int'(reload_i);
      end else if (pm_global_en_i && timers_en_i && unit_en_i && !acpi_mode_i
                   && tick_i && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        exp_now = (m_cnt == 0);
      end
      if (exp_now) m_sts = 1;
      else if (sts_clr_i) m_sts = 0;
      m_smi = m_sts && !acpi_mode_i && pm_global_en_i;
      m_uen_prev = unit_en_i;
    end
  end

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      n_cmp++;
      if (sts_o !== m_sts || smi_req_o !== m_smi) begin
        n_bad++;
        $display("FAIL %s cycle %0d: sts=%0b smi=%0b expected sts=%0b smi=%0b",
                 cur_req, cyc, sts_o, smi_req_o, m_sts, m_smi);
      end
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: ran=1 expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic expect_out(string tag, bit e_sts, bit e_smi);
    n_cmp++;
    if (sts_o !== e_sts || smi_req_o !== e_smi) begin
      n_bad++;
      $display("FAIL %s: sts=%0b smi=%0b expected sts=%0b smi=%0b",
               tag, sts_o, smi_req_o, e_sts, e_smi);
    end
  endtask

  // Each call spends one cycle: inputs are driven at a negative edge.
  task automatic step(bit t, bit h = 0, bit c = 0);
    @(negedge clk);
    tick_i = t; hit_i = h; sts_clr_i = c;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1);
    step(0);
  endtask

  task automatic clear_sts();
    step(0, 0, 1);
    step(0);
  endtask

  task automatic restart(int val);
    @(negedge clk);
    unit_en_i = 0; tick_i = 0; hit_i = 0; sts_clr_i = 1;
    @(negedge clk);
    reload_i = CNT_W'(val); unit_en_i = 1; sts_clr_i = 0;
    step(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 0, 0);
    rst = 0;
    pm_global_en_i = 1; timers_en_i = 1; acpi_mode_i = 0;

    cur_req = "R2";
    restart(5);
    ticks(4);  expect_out("R2 four ticks", 0, 0);
    step(0); step(0); expect_out("R2 idle cycles", 0, 0);
    ticks(1);  expect_out("R2 expiry", 1, 1);

    cur_req = "R3";
    step(0); step(0); expect_out("R3 sticky", 1, 1);
    clear_sts(); expect_out("R3 cleared", 0, 0);

    cur_req = "R9";
    ticks(20); expect_out("R9 one per period", 0, 0);

    cur_req = "R4";
    restart(5);
    ticks(3); step(0, 1); ticks(4); expect_out("R4 postponed", 0, 0);
    ticks(1); expect_out("R4 expiry after reload", 1, 1);

    cur_req = "R5";
    restart(5);
    ticks(2);
    timers_en_i = 0; ticks(10); expect_out("R5 frozen", 0, 0);
    timers_en_i = 1; ticks(2); expect_out("R5 resumed", 0, 0);
    ticks(1); expect_out("R5 expiry from held count", 1, 1);

    cur_req = "R6";
    restart(5);
    acpi_mode_i = 1; ticks(10); expect_out("R6 acpi no count", 0, 0);
    acpi_mode_i = 0; ticks(5); expect_out("R6 apm expiry", 1, 1);
    acpi_mode_i = 1; step(0); step(0); expect_out("R6 acpi masks smi", 1, 0);
    acpi_mode_i = 0; step(0); step(0);

    cur_req = "R7";
    pm_global_en_i = 0; step(0); step(0); expect_out("R7 pm off masks smi", 1, 0);
    pm_global_en_i = 1; restart(4);
    pm_global_en_i = 0; ticks(10); expect_out("R7 pm off no count", 0, 0);
    pm_global_en_i = 1; ticks(4); expect_out("R7 pm on expiry", 1, 1);

    cur_req = "R8";
    restart(3);
    ticks(2); step(1, 1); step(0); expect_out("R8 hit wins", 0, 0);
    ticks(3); expect_out("R8 later expiry", 1, 1);

    cur_req = "R10";
    restart(5);
    ticks(2);
    unit_en_i = 0; step(0);
    reload_i = CNT_W'(8); unit_en_i = 1; step(0);
    ticks(7); expect_out("R10 reloaded on rise", 0, 0);
    ticks(1); expect_out("R10 expiry", 1, 1);

    cur_req = "R11";
    restart(2);
    ticks(1); step(1, 0, 1); step(0); expect_out("R11 set beats clear", 1, 1);

    cur_req = "R12";
    restart(0);
    ticks(10); expect_out("R12 zero reload", 0, 0);

    step(0); step(0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule